// File: doc/BRIEF.md
# CPU I/O Port with Wait-State Control for a Serial Exchange Engine

This block attaches a serial byte-exchange engine to the 8-bit I/O space of an asynchronous microprocessor bus. The CPU's I/O request, read and write strobes, its address, its write data and its clock PHI all reach the block unsynchronised. Each is passed through a register chain into the fast fabric clock before any decoding. Two ports are decoded: a data port at `DATA_PORT` and a control port at `CTRL_PORT`.

A write to the data port hands the byte to the engine and starts an exchange. The bus cycle then ends without waiting for the exchange to finish. A read of the data port returns the byte received by the last completed exchange. When auto-restart is enabled, the same read also starts a new exchange that sends 0xFF, so block-input instructions can stream bytes back to back.

If a data-port access arrives while an exchange is still running, the block holds the CPU with the active-low wait output. That output feeds an external flip-flop clocked by PHI. To meet that flip-flop's setup time, the wait output changes only in the fabric cycle just after a synchronised rising edge of PHI. The CPU is expected to add at least one wait state to every I/O cycle.

Top module: `cpu_io_port`

## Requirements
- R1: While reset is held, `wait_n` is 1, `spi_cs_n` is 1, `spi_div` is 0, `spi_start` is 0 and `dout_en` is 0.
- R2: An access is acted on once per bus cycle. The trigger is the assertion of the synchronised strobe (I/O request low together with read low, or with write low). Holding the strobe for many cycles produces no further action until it is released.
- R3: A write to the data port (address 0x40) while no exchange is running pulses `spi_start` for exactly one cycle, with `spi_tx` equal to the written byte. The bus cycle completes with `wait_n` staying 1.
- R4: A read of the data port returns on `dout` the `spi_rx` byte from the last completed exchange. If auto-restart is set, the read also starts one exchange with `spi_tx` = 0xFF.
- R5: When auto-restart is clear, a read of the data port starts no exchange.
- R6: The control port (address 0x41) has this layout. Bit 0 is chip select, with `spi_cs_n` = NOT bit 0. Bit 1 is the divider select, driven on `spi_div`. Bit 2 is auto-restart. Bit 7 is busy and is read-only. Bits 6..3 read as 0. Control reads never wait.
- R7: `wait_n` changes value only in the cycle after a synchronised rising edge of PHI has been detected.
- R8: A data-port access that arrives while an exchange is busy is deferred. `wait_n` goes low at the next detected PHI rise. The access is carried out once the engine is idle, and `wait_n` returns to 1 at the first detected PHI rise after that. `spi_start` is never pulsed while `spi_busy` is high.
- R9: Only the 8 address bits are decoded. An access to any other address starts no exchange and leaves the control bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi | input | 1 | CPU clock, asynchronous |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | I/O address |
| din | input | DATA_W | CPU write data |
| dout | output | DATA_W | Read data toward the CPU |
| dout_en | output | 1 | Drive enable for `dout` during a decoded read |
| wait_n | output | 1 | Wait request to the PHI-clocked flip-flop, active low |
| spi_start | output | 1 | One-cycle start pulse to the exchange engine |
| spi_tx | output | DATA_W | Byte to transmit, valid with `spi_start` |
| spi_busy | input | 1 | Engine busy, high from the cycle after start until done |
| spi_rx | input | DATA_W | Byte received by the last exchange |
| spi_cs_n | output | 1 | Chip select to the serial device, active low |
| spi_div | output | 1 | Serial clock divider select |

## Verification
Four properties are checked on every cycle. `wait_n` never changes except just after a detected PHI rise. The start pulse lasts exactly one cycle and never lands on a busy engine. Each strobe assertion yields a single trigger. The control bits move only on a decoded control write. Only the bench's bus scenarios can show the data path: returned bytes, the 0xFF restart and its absence, deferral of a write or read behind a long exchange with the CPU actually held, and the ignored address.

// File: rtl/cpu_io_pkg.sv
package cpu_io_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } bus_op_e;

  localparam int unsigned CB_CS   = 0;
  localparam int unsigned CB_DIV  = 1;
  localparam int unsigned CB_AUTO = 2;
endpackage

// File: rtl/cio_sync.sv
module cio_sync #(
  parameter int unsigned W = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_l,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/cio_edge.sv
module cio_edge (
  input  logic clk,
  input  logic rst_l,
  input  logic phi_s,
  input  logic iorq_s,
  input  logic rd_s,
  input  logic wr_s,
  output logic phi_rise,
  output logic rd_go,
  output logic wr_go,
  output logic rd_act
);
  logic phi_p, rd_p, wr_p;
  logic rd_strb, wr_strb;

  assign rd_strb  = ~iorq_s & ~rd_s;
  assign wr_strb  = ~iorq_s & ~wr_s;
  assign rd_act   = rd_strb;
  assign phi_rise = phi_s & ~phi_p;
  assign rd_go    = rd_strb & ~rd_p;
  assign wr_go    = wr_strb & ~wr_p;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      phi_p <= 1'b0;
      rd_p  <= 1'b0;
      wr_p  <= 1'b0;
    end else begin
      phi_p <= phi_s;
      rd_p  <= rd_strb;
      wr_p  <= wr_strb;
    end
  end

  AST_ONE_TRIGGER_RD: assert property (@(posedge clk) disable iff (!rst_l)
    rd_go |=> !rd_go); // R2
  AST_ONE_TRIGGER_WR: assert property (@(posedge clk) disable iff (!rst_l)
    wr_go |=> !wr_go); // R2
endmodule

// File: rtl/cio_wait.sv
module cio_wait (
  input  logic clk,
  input  logic rst_l,
  input  logic phi_rise,
  input  logic stall,
  output logic wait_n
);
  logic wait_q, wait_d;

  always_comb begin
    wait_d = wait_q;
    if (phi_rise) wait_d = stall;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) wait_q <= 1'b0;
    else        wait_q <= wait_d;
  end

  assign wait_n = ~wait_q;

  AST_WAIT_AT_PHI: assert property (@(posedge clk) disable iff (!rst_l)
    !$stable(wait_n) |-> $past(phi_rise)); // R7
endmodule

// File: rtl/cpu_io_port.sv
module cpu_io_port
  import cpu_io_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DATA_PORT = 8'h40,
  parameter logic [ADDR_W-1:0] CTRL_PORT = 8'h41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              wait_n,
  output logic              spi_start,
  output logic [DATA_W-1:0] spi_tx,
  input  logic              spi_busy,
  input  logic [DATA_W-1:0] spi_rx,
  output logic              spi_cs_n,
  output logic              spi_div
);
  localparam int unsigned IN_W = 4 + ADDR_W + DATA_W;
  localparam logic [IN_W-1:0] IN_RST = {1'b0, 3'b111, {(ADDR_W + DATA_W){1'b0}}};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sr;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= 2'b00;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign rst_l = rst_sr[1];

  // input synchronisers
  logic [IN_W-1:0]   raw, syn;
  logic              phi_s, iorq_s, rd_s, wr_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;

  assign raw = {phi, iorq_n, rd_n, wr_n, addr, din};
  cio_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk(clk), .rst_l(rst_l), .d(raw), .q(syn)
  );
  assign {phi_s, iorq_s, rd_s, wr_s, addr_s, din_s} = syn;

  logic phi_rise, rd_go, wr_go, rd_act;
  cio_edge u_edge (
    .clk(clk), .rst_l(rst_l), .phi_s(phi_s), .iorq_s(iorq_s), .rd_s(rd_s),
    .wr_s(wr_s), .phi_rise(phi_rise), .rd_go(rd_go), .wr_go(wr_go), .rd_act(rd_act)
  );

  // state
  logic              start_q, start_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  bus_op_e           pend_q, pend_d;
  logic [DATA_W-1:0] pdat_q, pdat_d;
  logic              cs_q, cs_d, div_q, div_d, auto_q, auto_d;

  logic              sel_data, sel_ctrl, busy_eff, ctrl_wr;
  bus_op_e           new_op, exec_op;
  logic [DATA_W-1:0] exec_dat, ctrl_rd;

  assign sel_data = (addr_s == DATA_PORT);
  assign sel_ctrl = (addr_s == CTRL_PORT);
  assign busy_eff = spi_busy | start_q;
  assign ctrl_wr  = wr_go & sel_ctrl;

  always_comb begin
    new_op = OP_NONE;
    if (sel_data && rd_go)      new_op = OP_RD;
    else if (sel_data && wr_go) new_op = OP_WR;
  end

  always_comb begin
    pend_d   = pend_q;
    pdat_d   = pdat_q;
    exec_op  = OP_NONE;
    exec_dat = din_s;
    if (pend_q != OP_NONE) begin
      if (!busy_eff) begin
        exec_op  = pend_q;
        exec_dat = pdat_q;
        pend_d   = OP_NONE;
      end
    end else if (new_op != OP_NONE) begin
      if (busy_eff) begin
        pend_d = new_op;
        pdat_d = din_s;
      end else begin
        exec_op = new_op;
      end
    end
  end

  always_comb begin
    start_d = 1'b0;
    tx_d    = tx_q;
    rdata_d = rdata_q;
    case (exec_op)
      OP_WR: begin
        start_d = 1'b1;
        tx_d    = exec_dat;
      end
      OP_RD: begin
        rdata_d = spi_rx;
        if (auto_q) begin
          start_d = 1'b1;
          tx_d    = '1;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    cs_d   = cs_q;
    div_d  = div_q;
    auto_d = auto_q;
    if (ctrl_wr) begin
      cs_d   = din_s[CB_CS];
      div_d  = din_s[CB_DIV];
      auto_d = din_s[CB_AUTO];
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      start_q <= 1'b0;
      tx_q    <= '0;
      rdata_q <= '0;
      pend_q  <= OP_NONE;
      pdat_q  <= '0;
      cs_q    <= 1'b0;
      div_q   <= 1'b0;
      auto_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      tx_q    <= tx_d;
      rdata_q <= rdata_d;
      pend_q  <= pend_d;
      pdat_q  <= pdat_d;
      cs_q    <= cs_d;
      div_q   <= div_d;
      auto_q  <= auto_d;
    end
  end

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[CB_CS]   = cs_q;
    ctrl_rd[CB_DIV]  = div_q;
    ctrl_rd[CB_AUTO] = auto_q;
    ctrl_rd[DATA_W-1] = busy_eff;
  end

  cio_wait u_wait (
    .clk(clk), .rst_l(rst_l), .phi_rise(phi_rise),
    .stall(pend_q != OP_NONE), .wait_n(wait_n)
  );

  assign dout      = sel_ctrl ? ctrl_rd : rdata_q;
  assign dout_en   = rd_act & (sel_data | sel_ctrl);
  assign spi_start = start_q;
  assign spi_tx    = tx_q;
  assign spi_cs_n  = ~cs_q;
  assign spi_div   = div_q;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_l)
    spi_start |=> !spi_start); // R3
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_l)
    spi_start |-> !spi_busy); // R8
  AST_CTRL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_l)
    !$stable(spi_cs_n) |-> $past(ctrl_wr)); // R6
endmodule

// File: tb/cpu_io_port_tb_top.sv
`timescale 1ns/1ps
module cpu_io_port_tb_top;
  logic clk = 1'b0;
  logic phi = 1'b0;
  logic rst_n, iorq_n, rd_n, wr_n;
  logic [7:0] addr, din, dout, spi_tx, spi_rx;
  logic dout_en, wait_n, spi_start, spi_busy, spi_cs_n, spi_div;

  int errors = 0;
  int checks = 0;
  int starts = 0;
  int len = 20;
  int cnt = 0;
  logic [7:0] last_tx = 8'h00;

  always #5 clk = ~clk;
  always #50 phi = ~phi;

  cpu_io_port dut_i (
    .clk(clk), .rst_n(rst_n), .phi(phi), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .wait_n(wait_n),
    .spi_start(spi_start), .spi_tx(spi_tx), .spi_busy(spi_busy), .spi_rx(spi_rx),
    .spi_cs_n(spi_cs_n), .spi_div(spi_div)
  );

  // behavioural exchange engine: received byte = sent byte XOR 0xA5
  assign spi_busy = (cnt != 0);
  always @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= 0;
      spi_rx <= 8'h00;
    end else if (spi_start) begin
      cnt     <= len;
      last_tx <= spi_tx;
      starts  <= starts + 1;
    end else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) spi_rx <= last_tx ^ 8'hA5;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input logic [7:0] a, input logic [7:0] d,
                     output logic [7:0] q, output bit ws);
    @(negedge phi);
    addr = a; din = d; iorq_n = 1'b0; ws = 1'b0;
    if (wr) wr_n = 1'b0; else rd_n = 1'b0;
    repeat (3) begin
      @(negedge phi);
      if (!wait_n) ws = 1'b1;
    end
    while (!wait_n) begin
      ws = 1'b1;
      @(negedge phi);
    end
    q = dout;
    iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    @(negedge phi);
  endtask

  // {write, address, data, expected read, expected start count}
  localparam bit [32:0] VEC [8] = '{
    {1'b1, 8'h41, 8'h05, 8'h00, 8'd0},
    {1'b0, 8'h41, 8'h00, 8'h05, 8'd0},
    {1'b1, 8'h40, 8'h3C, 8'h00, 8'd1},
    {1'b0, 8'h40, 8'h00, 8'h99, 8'd2},
    {1'b0, 8'h40, 8'h00, 8'h5A, 8'd3},
    {1'b1, 8'h41, 8'h03, 8'h00, 8'd3},
    {1'b0, 8'h40, 8'h00, 8'h5A, 8'd3},
    {1'b0, 8'h41, 8'h00, 8'h03, 8'd3}
  };

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] q;
    bit ws;
    rst_n = 1'b0; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = 8'h00; din = 8'h00;
    repeat (5) @(posedge clk);
    #2;
    check("R1 wait_n", wait_n, 1);
    check("R1 spi_cs_n", spi_cs_n, 1);
    check("R1 spi_div", spi_div, 0);
    check("R1 spi_start", spi_start, 0);
    check("R1 dout_en", dout_en, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    for (int i = 0; i < 8; i++) begin
      bus(VEC[i][32], VEC[i][31:24], VEC[i][23:16], q, ws);
      if (VEC[i][32]) begin
        check("R3 no wait when idle", ws, 0);
        if (VEC[i][31:24] == 8'h40) check("R3 tx byte", last_tx, VEC[i][23:16]);
      end else begin
        check(VEC[i][31:24] == 8'h41 ? "R6 control read" : "R4 data read", q, VEC[i][15:8]);
      end
      check("R2/R5 start count", starts, VEC[i][7:0]);
      if (!VEC[i][32] && VEC[i][31:24] == 8'h40 && VEC[i][7:0] != VEC[i-1][7:0])
        check("R4 restart byte", last_tx, 8'hFF);
    end
    check("R6 cs pin", spi_cs_n, 0);
    check("R6 div pin", spi_div, 1);

    // R9: unmapped address
    bus(1'b1, 8'h42, 8'h00, q, ws);
    bus(1'b1, 8'hC0, 8'h77, q, ws);
    check("R9 no start", starts, 3);
    bus(1'b0, 8'h41, 8'h00, q, ws);
    check("R9 control unchanged", q, 8'h03);

    // R8: accesses behind a long exchange
    len = 300;
    bus(1'b1, 8'h41, 8'h05, q, ws);
    check("R6 div cleared", spi_div, 0);
    bus(1'b1, 8'h40, 8'h11, q, ws);
    check("R3 write idle no wait", ws, 0);
    check("R3 start count", starts, 4);
    bus(1'b0, 8'h41, 8'h00, q, ws);
    check("R6 busy bit", q, 8'h85);
    check("R6 control read no wait", ws, 0);
    bus(1'b1, 8'h40, 8'h22, q, ws);
    check("R8 write held", ws, 1);
    check("R8 deferred start", starts, 5);
    check("R8 deferred tx", last_tx, 8'h22);
    check("R8 first exchange done", spi_rx, 8'hB4);
    check("R7 wait released", wait_n, 1);
    bus(1'b0, 8'h40, 8'h00, q, ws);
    check("R8 read held", ws, 1);
    check("R8 deferred read data", q, 8'h87);
    check("R4 deferred restart", starts, 6);
    check("R4 restart tx", last_tx, 8'hFF);
    check("R7 wait released after read", wait_n, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule